// File: doc/BRIEF.md
# Serial SAR ADC Frame Controller

This block is the host-side master for a 14-bit successive-approximation converter with a serial result output. On request it drives chip select low, optionally raises a frame-sync strobe, and produces sixteen serial clock pulses divided down from the system clock. During those pulses it shifts in the 14 result bits, most significant bit first. It then waits for the converter's conversion-busy signal to rise and fall before it reports the result and accepts the next frame. The block also drives the converter's active-low powerdown/reset pin, either as a short reset pulse or as a powerdown hold that lasts as long as the host asks. After power-on, a reset or a powerdown, the converter needs four conversions to initialise, so the block discards the first four completed results. All delays are counted in system clocks and set by parameters.

The sequencer has six states. ST_IDLE waits for a request. ST_SETUP holds chip select low before the clocks start and raises the strobe. ST_SHIFT runs the sixteen serial clocks. ST_CONV waits on conversion-busy. ST_RST drives the reset pulse. ST_PWD holds powerdown. The transitions are:
- ST_IDLE to ST_SETUP on start_frame while adc_busy is low.
- ST_SETUP to ST_SHIFT after CLK_DIV clocks.
- ST_SHIFT to ST_CONV at the end of the 16th serial clock period.
- ST_CONV to ST_IDLE when busy has been seen high and then low, or when the timeout expires.
- ST_RST to ST_IDLE after RST_LOW clocks.
- ST_PWD to ST_IDLE once powerdown_req is low and at least PWD_MIN clocks have passed.
- Any state to ST_PWD on powerdown_req.
- Any state except ST_RST and ST_PWD to ST_RST on reset_req.

Top module: `sar_frame_ctrl`

## Requirements
- R1: Out of reset, adc_cs_n is 1, adc_sclk is 0, adc_pd_n is 1, data_valid is 0 and busy_timeout_err is 0. adc_fs is 0 when sync_mode is 1.
- R2: In ST_IDLE, start_frame with adc_busy low starts a frame. adc_cs_n goes low, and adc_sclk makes exactly 16 rising edges while adc_cs_n is low. adc_sclk is never high while adc_cs_n is high. When sync_mode is 1, adc_fs is high for CLK_DIV-1 clocks, starting one clock after adc_cs_n falls, and is low for the rest of the frame. A start_frame that arrives while adc_busy is high is ignored.
- R3: Each serial clock period lasts CLK_DIV system clocks. adc_sclk is high for CLK_DIV/2 of them, at the start of the period.
- R4: adc_sdo is sampled at falling edges 1 to 14 of adc_sclk. The first sample becomes data_out[13] and the 14th becomes data_out[0]. Samples at falling edges 15 and 16 have no effect on data_out.
- R5: adc_cs_n stays low for exactly 17*CLK_DIV system clocks in a frame that is not interrupted. It rises at the end of the 16th serial clock period.
- R6: After a frame, the block waits until adc_busy has been seen high and then low. Only then does it complete the frame and accept a new start.
- R7: The first four frames to complete after rst_n, reset_req or a powerdown produce no data_valid. Every later completed frame produces exactly one single-cycle data_valid pulse, with data_out holding that frame's result.
- R8: If adc_busy has not risen and fallen within BUSY_TIMEOUT clocks after adc_cs_n rises, busy_timeout_err is set and the block returns to ST_IDLE without data_valid. busy_timeout_err is cleared only by rst_n. A timed-out frame does not count toward the four warm-up frames.
- R9: reset_req drives adc_pd_n low for exactly RST_LOW clocks, starting one clock after the request. The request aborts any frame in progress: adc_cs_n is high while adc_pd_n is low. It also restarts the warm-up count.
- R10: powerdown_req drives adc_pd_n low from one clock after it is raised. adc_pd_n stays low for as many clocks as the request was held, with a minimum of PWD_MIN clocks, and the warm-up count restarts.
- R11: When sync_mode is 0, adc_fs is held at 1 in every state, and chip select alone frames the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_frame | input | 1 | Request one conversion frame |
| reset_req | input | 1 | Request a reset pulse on the converter |
| powerdown_req | input | 1 | Hold the converter in powerdown while high |
| sync_mode | input | 1 | 1: strobe framing on adc_fs, 0: adc_fs held high |
| adc_sdo | input | 1 | Serial result bit from the converter |
| adc_busy | input | 1 | Converter conversion-busy flag |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock |
| adc_fs | output | 1 | Frame-sync strobe |
| adc_pd_n | output | 1 | Active-low powerdown/reset pin |
| data_out | output | 14 | Last reported result |
| data_valid | output | 1 | One-cycle pulse when data_out is updated |
| busy_timeout_err | output | 1 | Sticky flag for a conversion that timed out |

## Verification
On every cycle, the assertions check these pin relationships:
- The serial clock and the strobe stay inside chip select.
- Chip select never falls right after a cycle in which busy was high.
- Chip select stays high while the reset or powerdown pin is low.
- The strobe is held high in the alternative mode.
- The reset and powerdown requests reach the pin one clock later.
- data_valid is a single pulse that occurs only once warm-up has saturated.
- The timeout flag is sticky.

Only the bench scenarios can show the remaining behaviour:
- The result bit order, and that the 15th and 16th samples are ignored.
- The exact chip-select, strobe and clock-high widths.
- That four results are discarded after each kind of restart.
- The timeout instant.
- The reset pulse length, and the powerdown hold length for both long and short requests.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_CONV,
        ST_RST,
        ST_PWD
    } sar_state_t;

endpackage

// File: rtl/sar_sclk_div.sv
// Serial clock generator: runs only while enabled, high for the first
// half of each period, with single-cycle markers for the falling edge
// and the last system clock of a period.
module sar_sclk_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic fall_now,
    output logic period_end
);
    localparam int HI = CLK_DIV / 2;
    localparam int CW = $clog2(CLK_DIV);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (cnt == CW'(CLK_DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sclk       = en && (cnt < CW'(HI));
    assign fall_now   = en && (cnt == CW'(HI - 1));
    assign period_end = en && (cnt == CW'(CLK_DIV - 1));

endmodule

// File: rtl/sar_shift_in.sv
// MSB-first serial-to-parallel capture register.
module sar_shift_in #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clr) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[DATA_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/sar_warmup.sv
// Saturating count of completed conversions since the last restart.
module sar_warmup #(
    parameter int WARM_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic sat
);
    localparam int WW = $clog2(WARM_FRAMES + 1);

    logic [WW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != WW'(WARM_FRAMES))) begin
            count <= count + 1'b1;
        end
    end

    assign sat = (count == WW'(WARM_FRAMES));
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W       = 14,
    parameter int FRAME_CLKS   = 16,
    parameter int CLK_DIV      = 4,
    parameter int BUSY_TIMEOUT = 64,
    parameter int RST_LOW      = 8,
    parameter int PWD_MIN      = 32,
    parameter int WARM_FRAMES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_frame,
    input  logic              reset_req,
    input  logic              powerdown_req,
    input  logic              sync_mode,
    input  logic              adc_sdo,
    input  logic              adc_busy,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_fs,
    output logic              adc_pd_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              busy_timeout_err
);
    localparam int FW  = $clog2(FRAME_CLKS + 1);
    localparam int TM1 = (CLK_DIV > BUSY_TIMEOUT) ? CLK_DIV : BUSY_TIMEOUT;
    localparam int TM2 = (RST_LOW > PWD_MIN) ? RST_LOW : PWD_MIN;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int TW  = $clog2(TMAX + 1);

    sar_state_t        state_q;
    sar_state_t        state_d;
    logic [TW-1:0]     tcnt;
    logic [FW-1:0]     fcnt;
    logic              busy_seen;
    logic              sclk_en;
    logic              sclk_w;
    logic              fall_now;
    logic              period_end;
    logic [DATA_W-1:0] word;
    logic              warm_sat;
    logic              setup_done;
    logic              shift_done;
    logic              conv_done;
    logic              conv_to;
    logic              rst_done;
    logic              pwd_release;
    logic              shift_en;
    logic              warm_clr;
    logic              warm_inc;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;

    // ---------------- sub-blocks ----------------
    assign sclk_en = (state_q == ST_SHIFT);

    sar_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sclk_en),
        .sclk       (sclk_w),
        .fall_now   (fall_now),
        .period_end (period_end)
    );

    assign shift_en = (state_q == ST_SHIFT) && fall_now && (fcnt < FW'(DATA_W));

    sar_shift_in #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_SETUP),
        .shift_en (shift_en),
        .bit_in   (adc_sdo),
        .word     (word)
    );

    assign warm_clr = (state_q == ST_RST) || (state_q == ST_PWD);
    assign warm_inc = (state_q == ST_CONV) && conv_done && !warm_sat;

    sar_warmup #(.WARM_FRAMES(WARM_FRAMES)) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (warm_clr),
        .inc   (warm_inc),
        .sat   (warm_sat)
    );

    // ---------------- transition conditions ----------------
    assign setup_done  = (tcnt == TW'(CLK_DIV - 1));
    assign shift_done  = period_end && (fcnt == FW'(FRAME_CLKS));
    assign conv_done   = busy_seen && !adc_busy;
    assign conv_to     = (tcnt == TW'(BUSY_TIMEOUT - 1)) && !conv_done;
    assign rst_done    = (tcnt == TW'(RST_LOW - 1));
    assign pwd_release = !powerdown_req && (tcnt >= TW'(PWD_MIN - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (powerdown_req && (state_q != ST_PWD)) begin
            state_d = ST_PWD;
        end else if (reset_req && (state_q != ST_RST) && (state_q != ST_PWD)) begin
            state_d = ST_RST;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_frame && !adc_busy) state_d = ST_SETUP;
                ST_SETUP: if (setup_done) state_d = ST_SHIFT;
                ST_SHIFT: if (shift_done) state_d = ST_CONV;
                ST_CONV:  if (conv_done || conv_to) state_d = ST_IDLE;
                ST_RST:   if (rst_done) state_d = ST_IDLE;
                ST_PWD:   if (pwd_release) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- counters and result registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            fcnt      <= '0;
            busy_seen <= 1'b0;
            valid_q   <= 1'b0;
            data_q    <= '0;
            err_q     <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                tcnt <= '0;
            end else if (tcnt != '1) begin
                tcnt <= tcnt + 1'b1;
            end

            if (state_q != ST_SHIFT) begin
                fcnt <= '0;
            end else if (fall_now) begin
                fcnt <= fcnt + 1'b1;
            end

            if (state_q != ST_CONV) begin
                busy_seen <= 1'b0;
            end else if (adc_busy) begin
                busy_seen <= 1'b1;
            end

            valid_q <= (state_q == ST_CONV) && conv_done && warm_sat;
            if ((state_q == ST_CONV) && conv_done && warm_sat) begin
                data_q <= word;
            end

            if ((state_q == ST_CONV) && conv_to) begin
                err_q <= 1'b1;
            end
        end
    end

    // ---------------- pin outputs ----------------
    always_comb begin
        adc_cs_n = !((state_q == ST_SETUP) || (state_q == ST_SHIFT));
        adc_pd_n = !((state_q == ST_RST) || (state_q == ST_PWD));
        adc_sclk = sclk_w;
        if (sync_mode) begin
            adc_fs = (state_q == ST_SETUP) && (tcnt != '0);
        end else begin
            adc_fs = 1'b1;
        end
    end

    assign data_out         = data_q;
    assign data_valid       = valid_q;
    assign busy_timeout_err = err_q;

endmodule

// File: rtl/sar_frame_ctrl_chk.sv
module sar_frame_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic reset_req,
    input logic powerdown_req,
    input logic sync_mode,
    input logic adc_busy,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_fs,
    input logic adc_pd_n,
    input logic data_valid,
    input logic busy_timeout_err,
    input logic warm_sat
);
    p_sclk_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cs_n);

    p_fs_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && adc_fs) |-> !adc_cs_n);

    p_no_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> !$past(adc_busy));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    p_valid_warm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(warm_sat));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_timeout_err |=> busy_timeout_err);

    p_rst_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && adc_pd_n) |=> !adc_pd_n);

    p_cs_idle_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_pd_n |-> adc_cs_n);

    p_pwd_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        powerdown_req |=> !adc_pd_n);

    p_fs_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |-> adc_fs);
endmodule

bind sar_frame_ctrl sar_frame_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reset_req        (reset_req),
    .powerdown_req    (powerdown_req),
    .sync_mode        (sync_mode),
    .adc_busy         (adc_busy),
    .adc_cs_n         (adc_cs_n),
    .adc_sclk         (adc_sclk),
    .adc_fs           (adc_fs),
    .adc_pd_n         (adc_pd_n),
    .data_valid       (data_valid),
    .busy_timeout_err (busy_timeout_err),
    .warm_sat         (warm_sat)
);

// File: tb/tb_sar_frame_ctrl.sv
`timescale 1ns/1ps
module tb_sar_frame_ctrl;
    localparam int DATA_W       = 14;
    localparam int CLK_DIV      = 4;
    localparam int BUSY_TIMEOUT = 64;
    localparam int RST_LOW      = 8;
    localparam int PWD_MIN      = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_frame = 1'b0;
    logic reset_req = 1'b0;
    logic powerdown_req = 1'b0;
    logic sync_mode = 1'b1;
    logic adc_sdo = 1'b0;
    logic adc_busy;
    logic adc_cs_n, adc_sclk, adc_fs, adc_pd_n;
    logic [DATA_W-1:0] data_out;
    logic data_valid, busy_timeout_err;

    logic mbusy = 1'b0;
    logic hold_busy = 1'b0;
    assign adc_busy = mbusy | hold_busy;

    logic [DATA_W-1:0] cur_word = '0;
    int busy_len = 4;

    int checks = 0;
    int failures = 0;
    bit reported = 0;
    int bwarm = 0;

    // monitor results
    int valid_cnt = 0, valid_long = 0, cs_falls = 0;
    logic [DATA_W-1:0] last_data = '0;
    int cs_run = 0, last_cs_low = 0;
    int rises = 0, last_rises = 0;
    int fs_cnt = 0, last_fs = 0;
    int hi_run = 0, hi_max = 0, hi_min = 1000, last_hi_max = 0, last_hi_min = 0;
    int pd_run = 0, last_pd_run = 0;
    int fs_low_free = 0;

    always #5 clk = ~clk;

    sar_frame_ctrl #(
        .DATA_W(DATA_W), .FRAME_CLKS(16), .CLK_DIV(CLK_DIV),
        .BUSY_TIMEOUT(BUSY_TIMEOUT), .RST_LOW(RST_LOW), .PWD_MIN(PWD_MIN),
        .WARM_FRAMES(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_frame(start_frame),
        .reset_req(reset_req), .powerdown_req(powerdown_req),
        .sync_mode(sync_mode), .adc_sdo(adc_sdo), .adc_busy(adc_busy),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_fs(adc_fs),
        .adc_pd_n(adc_pd_n), .data_out(data_out), .data_valid(data_valid),
        .busy_timeout_err(busy_timeout_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    // pin monitor, sampled at the falling clock edge
    initial begin
        logic pcs, psclk, ppd, pval;
        pcs = 1'b1; psclk = 1'b0; ppd = 1'b1; pval = 1'b0;
        forever begin
            @(negedge clk);
            if (data_valid) begin
                valid_cnt++;
                last_data = data_out;
                if (pval) valid_long++;
            end
            if (!sync_mode && !adc_fs) fs_low_free++;
            if (!adc_cs_n && pcs) cs_falls++;
            if (!adc_cs_n) cs_run++;
            if (sync_mode && adc_fs && !adc_cs_n) fs_cnt++;
            if (adc_sclk && !psclk) rises++;
            if (adc_sclk) hi_run++;
            else if (psclk) begin
                if (hi_run > hi_max) hi_max = hi_run;
                if (hi_run < hi_min) hi_min = hi_run;
                hi_run = 0;
            end
            if (adc_cs_n && !pcs) begin
                last_cs_low = cs_run; last_rises = rises; last_fs = fs_cnt;
                last_hi_max = hi_max; last_hi_min = hi_min;
                cs_run = 0; rises = 0; fs_cnt = 0; hi_max = 0; hi_min = 1000;
            end
            if (!adc_pd_n) pd_run++;
            else if (!ppd) begin
                last_pd_run = pd_run;
                pd_run = 0;
            end
            pcs = adc_cs_n; psclk = adc_sclk; ppd = adc_pd_n; pval = data_valid;
        end
    end

    // converter model
    initial begin
        forever begin
            int k;
            @(negedge adc_cs_n);
            adc_sdo = cur_word[DATA_W-1];
            k = 0;
            while (!adc_cs_n) begin
                @(posedge adc_sclk or posedge adc_cs_n);
                if (!adc_cs_n) begin
                    k++;
                    @(negedge clk);
                    if (k >= 2 && k <= 14) adc_sdo = cur_word[14-k];
                    else if (k > 14) adc_sdo = 1'($urandom_range(1, 0));
                end
            end
            if (busy_len > 0) begin
                @(negedge clk);
                mbusy = 1'b1;
                repeat (busy_len) @(negedge clk);
                mbusy = 1'b0;
            end
        end
    end

    task automatic start_pulse();
        @(negedge clk);
        while (adc_busy) @(negedge clk);
        start_frame = 1'b1;
        @(negedge clk);
        start_frame = 1'b0;
    endtask

    // one full frame; checks the reporting rule R7 and the bit order R4
    task automatic run_frame(input logic [DATA_W-1:0] w, input int blen, input string tag);
        int v0;
        bit expv;
        cur_word = w;
        busy_len = blen;
        v0 = valid_cnt;
        expv = (bwarm >= 4);
        start_pulse();
        @(posedge adc_cs_n);
        repeat (blen + 6) @(negedge clk);
        chk({tag, " R7 valid count"}, valid_cnt - v0, expv ? 1 : 0);
        if (expv) chk({tag, " R4 data"}, int'(last_data), int'(w));
        else bwarm++;
    endtask

    task automatic geom_check(input string tag);
        chk({tag, " R5 cs low width"}, last_cs_low, 17 * CLK_DIV);
        chk({tag, " R2 sclk rises"}, last_rises, 16);
        chk({tag, " R3 sclk high max"}, last_hi_max, CLK_DIV / 2);
        chk({tag, " R3 sclk high min"}, last_hi_min, CLK_DIV / 2);
    endtask

    initial begin
        void'($urandom(32'h5EED_0421));
        repeat (5) @(negedge clk);
        chk("R1 cs_n", int'(adc_cs_n), 1);
        chk("R1 sclk", int'(adc_sclk), 0);
        chk("R1 pd_n", int'(adc_pd_n), 1);
        chk("R1 fs", int'(adc_fs), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(data_valid), 0);
        chk("R1 err", int'(busy_timeout_err), 0);

        // warm-up after power-on: four frames are discarded
        run_frame(14'h1234, 3, "warm0");
        run_frame(14'h0F0F, 5, "warm1");
        run_frame(14'h3001, 2, "warm2");
        run_frame(14'h2222, 4, "warm3");
        run_frame(14'h2AAA, 4, "first");
        geom_check("first");
        chk("R2 fs high width", last_fs, CLK_DIV - 1);
        run_frame(14'h3FFF, 2, "ones");
        run_frame(14'h0000, 3, "zeros");
        run_frame(14'h2001, 6, "ends");
        geom_check("ends");

        // busy-gated completion with random results and busy lengths (R6)
        for (int i = 0; i < 20; i++) begin
            logic [DATA_W-1:0] w;
            w = DATA_W'($urandom);
            run_frame(w, int'($urandom_range(20, 2)), "rand R6");
            repeat (int'($urandom_range(5, 0))) @(negedge clk);
        end

        // start while busy is high is ignored (R2)
        begin
            int f0;
            f0 = cs_falls;
            @(negedge clk);
            hold_busy = 1'b1;
            start_frame = 1'b1;
            @(negedge clk);
            start_frame = 1'b0;
            repeat (10) @(negedge clk);
            chk("R2 start ignored while busy", cs_falls - f0, 0);
            hold_busy = 1'b0;
            repeat (3) @(negedge clk);
            chk("R2 no late start", cs_falls - f0, 0);
        end

        // chip-select-only framing (R11)
        sync_mode = 1'b0;
        fs_low_free = 0;
        run_frame(14'h1555, 3, "spi0 R11");
        run_frame(14'h0ACE, 5, "spi1 R11");
        geom_check("spi1");
        chk("R11 fs held high", fs_low_free, 0);
        sync_mode = 1'b1;

        // busy timeout (R8)
        begin
            int v0;
            v0 = valid_cnt;
            cur_word = 14'h1111;
            busy_len = 0;
            start_pulse();
            @(posedge adc_cs_n);
            repeat (BUSY_TIMEOUT - 2) @(negedge clk);
            chk("R8 err not yet", int'(busy_timeout_err), 0);
            repeat (6) @(negedge clk);
            chk("R8 err set", int'(busy_timeout_err), 1);
            chk("R8 no valid on timeout", valid_cnt - v0, 0);
            run_frame(14'h0777, 4, "after_to R8");
            chk("R8 err sticky", int'(busy_timeout_err), 1);
        end

        // reset pulse aborting a frame (R9)
        begin
            int v0;
            v0 = valid_cnt;
            cur_word = 14'h2BCD;
            busy_len = 3;
            start_pulse();
            repeat (20) @(negedge clk);
            reset_req = 1'b1;
            @(negedge clk);
            reset_req = 1'b0;
            repeat (2) @(negedge clk);
            chk("R9 pd low", int'(adc_pd_n), 0);
            chk("R9 cs high during reset", int'(adc_cs_n), 1);
            repeat (RST_LOW + 4) @(negedge clk);
            chk("R9 pd pulse width", last_pd_run, RST_LOW);
            chk("R9 aborted frame silent", valid_cnt - v0, 0);
            bwarm = 0;
            for (int i = 0; i < 5; i++)
                run_frame(DATA_W'($urandom), 3, "post_rst R9");
        end

        // long and short powerdown (R10)
        powerdown_req = 1'b1;
        repeat (50) @(negedge clk);
        powerdown_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 long hold width", last_pd_run, 50);
        powerdown_req = 1'b1;
        repeat (3) @(negedge clk);
        powerdown_req = 1'b0;
        repeat (PWD_MIN + 4) @(negedge clk);
        chk("R10 short hold min width", last_pd_run, PWD_MIN);
        bwarm = 0;
        for (int i = 0; i < 5; i++)
            run_frame(DATA_W'($urandom), 4, "post_pwd R10");

        chk("R7 valid single cycle", valid_long, 0);
        finish_run();
    end
endmodule